// File: doc/BRIEF.md
# Calendar Real-Time Clock with Alarm

This peripheral keeps a calendar time of second, minute, hour, weekday, day of month, month and a two-digit year. It advances on a once-per-second tick strobe from an external prescaler. Software reaches every field through a simple 32-bit register bus. A second bank of registers holds an alarm time. An alarm control byte chooses which fields must match. When the chosen fields agree with the counter, a sticky pending flag is raised and drives a level interrupt.

Software normally sets the stop bit, writes the time fields, and clears the stop bit again. It arms an alarm by writing the alarm bank and then the control byte. To service the interrupt it writes the control byte to zero and writes a one to the pending bit.

Top module: `cal_rtc`

## Requirements
- R1: After reset the time reads year 0, month 1, day 1, weekday 0, 00:00:00. The stop bit reads 1. The alarm fields, alarm control, debounce field and pending flag read 0, and `irq` is 0.
- R2: Field index i (0 year, 1 month, 2 day of month, 3 weekday, 4 hour, 5 minute, 6 second) is at byte address 0x40+4i for the time and 0x60+4i for the alarm. Reads return the field zero-extended to 32 bits. A write changes only the addressed field, and the new value is visible after the next clock edge.
- R3: Bit 0 of address 0x20 is the stop bit. While it is 1, tick pulses leave the time unchanged.
- R4: On a tick while running, the second advances. Second 59 wraps to 0 and carries into the minute. Minute 59 wraps to 0 and carries into the hour. Hour 23 wraps to 0 and carries into the day.
- R5: The day of month wraps to 1 after 30 days in months 4, 6, 9 and 11, and after 31 days in the other non-February months. Month 12 wraps to 1 and carries into the year.
- R6: February has 29 days when the year is 1..99 and a multiple of 4. In every other year, including year 0, it has 28 days.
- R7: Year 99 wraps to 0.
- R8: The weekday advances on each day carry, and 6 wraps to 0.
- R9: Address 0x7c holds the alarm control byte. Bit 0 enables the alarm, and bit i+1 includes field i in the compare. On a running tick with bit 0 set, the pending flag (bit 4 of 0x30) is set if every included field of the new time equals its alarm field. Excluded fields are ignored. With bit 0 clear, no match sets the flag.
- R10: `irq` is 1 exactly when the pending flag and alarm enable bit 0 are both 1. Writing 0 to 0x7c lowers `irq` and leaves the pending flag set.
- R11: Writing 0x30 with bit 4 set clears the pending flag. Writing it with bit 4 clear has no effect. If a match sets the flag in the same cycle as a clear, the flag ends up set.
- R12: Address 0x2c holds a 3-bit storage field with no other effect. Its upper bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tick_1hz | input | 1 | One-cycle pulse per second |
| bus_en | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| irq | output | 1 | Alarm interrupt, level |

## Verification
Two events can land in the same cycle: an alarm match raised by a tick, and a software write-one-to-clear of the pending flag. The bench arms a one-field alarm one second ahead. It then drives the tick and the clear write on the same clock edge. After that edge the pending bit must read 1 and `irq` must be high, which shows the set wins. The bench also checks that an ordinary clear write with no tick does remove the flag.

// File: rtl/cal_rtc_pkg.sv
package cal_rtc_pkg;

    localparam int YEAR_W = 7;
    localparam int MON_W  = 4;
    localparam int DOM_W  = 5;
    localparam int DOW_W  = 3;
    localparam int HOUR_W = 5;
    localparam int MIN_W  = 6;
    localparam int SEC_W  = 6;
    localparam int FIELD_W = 7;
    localparam int N_FIELDS = 7;

    typedef struct packed {
        logic [YEAR_W-1:0] year;
        logic [MON_W-1:0]  mon;
        logic [DOM_W-1:0]  dom;
        logic [DOW_W-1:0]  dow;
        logic [HOUR_W-1:0] hour;
        logic [MIN_W-1:0]  min;
        logic [SEC_W-1:0]  sec;
    } cal_t;

    function automatic logic [FIELD_W-1:0] get_field(cal_t c, logic [2:0] idx);
        logic [FIELD_W-1:0] v;
        case (idx)
            3'd0:    v = c.year;
            3'd1:    v = {3'b0, c.mon};
            3'd2:    v = {2'b0, c.dom};
            3'd3:    v = {4'b0, c.dow};
            3'd4:    v = {2'b0, c.hour};
            3'd5:    v = {1'b0, c.min};
            3'd6:    v = {1'b0, c.sec};
            default: v = '0;
        endcase
        return v;
    endfunction

    function automatic cal_t set_field(cal_t c, logic [2:0] idx, logic [FIELD_W-1:0] v);
        cal_t r;
        r = c;
        case (idx)
            3'd0:    r.year = v;
            3'd1:    r.mon  = v[MON_W-1:0];
            3'd2:    r.dom  = v[DOM_W-1:0];
            3'd3:    r.dow  = v[DOW_W-1:0];
            3'd4:    r.hour = v[HOUR_W-1:0];
            3'd5:    r.min  = v[MIN_W-1:0];
            3'd6:    r.sec  = v[SEC_W-1:0];
            default: r = c;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/cal_rtc_next.sv
module cal_rtc_next
    import cal_rtc_pkg::*;
#(
    parameter int YEAR_MAX = 99
) (
    input  cal_t cur,
    output cal_t nxt
);

    logic             leap;
    logic [DOM_W-1:0] dim;
    logic sec_c, min_c, day_c, dom_c;

    always_comb begin
        leap = (cur.year != '0) && (cur.year[1:0] == 2'b00);
        case (cur.mon)
            4'd2:                      dim = leap ? 5'd29 : 5'd28;
            4'd4, 4'd6, 4'd9, 4'd11:   dim = 5'd30;
            default:                   dim = 5'd31;
        endcase

        sec_c = (cur.sec >= 6'd59);
        min_c = sec_c && (cur.min >= 6'd59);
        day_c = min_c && (cur.hour >= 5'd23);
        dom_c = day_c && (cur.dom >= dim);

        nxt = cur;
        nxt.sec = sec_c ? '0 : cur.sec + 6'd1;
        if (sec_c) nxt.min  = (cur.min >= 6'd59) ? '0 : cur.min + 6'd1;
        if (min_c) nxt.hour = (cur.hour >= 5'd23) ? '0 : cur.hour + 5'd1;
        if (day_c) begin
            nxt.dow = (cur.dow >= 3'd6) ? '0 : cur.dow + 3'd1;
            nxt.dom = dom_c ? 5'd1 : cur.dom + 5'd1;
        end
        if (dom_c) begin
            nxt.mon = (cur.mon >= 4'd12) ? 4'd1 : cur.mon + 4'd1;
            if (cur.mon >= 4'd12)
                nxt.year = (cur.year >= YEAR_W'(YEAR_MAX)) ? '0 : cur.year + 7'd1;
        end
    end

endmodule

// File: rtl/cal_rtc_match.sv
module cal_rtc_match
    import cal_rtc_pkg::*;
(
    input  cal_t                now_t,
    input  cal_t                alm_t,
    input  logic [N_FIELDS-1:0] fld_en,
    output logic                hit
);

    logic [N_FIELDS-1:0] ok;

    for (genvar i = 0; i < N_FIELDS; i++) begin : g_cmp
        assign ok[i] = !fld_en[i] ||
                       (get_field(now_t, 3'(i)) == get_field(alm_t, 3'(i)));
    end

    assign hit = &ok;

endmodule

// File: rtl/cal_rtc.sv
module cal_rtc
    import cal_rtc_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 32,
    parameter int YEAR_MAX = 99,
    parameter int DBN_W    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1hz,
    input  logic              bus_en,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);

    localparam logic [ADDR_W-1:0] A_CTL   = ADDR_W'(8'h20);
    localparam logic [ADDR_W-1:0] A_DBN   = ADDR_W'(8'h2c);
    localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(8'h30);
    localparam logic [ADDR_W-1:0] A_ALCTL = ADDR_W'(8'h7c);
    localparam int PEND_BIT = 4;

    typedef struct packed {
        cal_t             tm;
        cal_t             al;
        logic             stop;
        logic [DBN_W-1:0] dbn;
        logic [7:0]       alctl;
        logic             pend;
    } state_t;

    state_t st_d, st_q;
    cal_t   tm_adv;
    logic   hit, adv, fire;
    logic   in_time, in_alm;
    logic [2:0] fidx;

    cal_rtc_next #(.YEAR_MAX(YEAR_MAX)) u_next (
        .cur (st_q.tm),
        .nxt (tm_adv)
    );

    cal_rtc_match u_match (
        .now_t  (tm_adv),
        .alm_t  (st_q.al),
        .fld_en (st_q.alctl[N_FIELDS:1]),
        .hit    (hit)
    );

    always_comb begin
        fidx    = bus_addr[4:2];
        in_time = (bus_addr[7:5] == 3'b010) && (fidx != 3'd7);
        in_alm  = (bus_addr[7:5] == 3'b011) && (fidx != 3'd7);
        adv     = tick_1hz && !st_q.stop;
        fire    = adv && st_q.alctl[0] && hit;

        st_d = st_q;
        if (adv) st_d.tm = tm_adv;
        if (bus_en && bus_wr) begin
            if (in_time)
                st_d.tm = set_field(st_d.tm, fidx, bus_wdata[FIELD_W-1:0]);
            else if (in_alm)
                st_d.al = set_field(st_d.al, fidx, bus_wdata[FIELD_W-1:0]);
            else if (bus_addr == A_CTL)
                st_d.stop = bus_wdata[0];
            else if (bus_addr == A_DBN)
                st_d.dbn = bus_wdata[DBN_W-1:0];
            else if (bus_addr == A_ALCTL)
                st_d.alctl = bus_wdata[7:0];
            else if (bus_addr == A_STAT && bus_wdata[PEND_BIT])
                st_d.pend = 1'b0;
        end
        if (fire) st_d.pend = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.tm.mon <= 4'd1;
            st_q.tm.dom <= 5'd1;
            st_q.stop   <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (in_time)
            bus_rdata = DATA_W'(get_field(st_q.tm, fidx));
        else if (in_alm)
            bus_rdata = DATA_W'(get_field(st_q.al, fidx));
        else if (bus_addr == A_CTL)
            bus_rdata = DATA_W'(st_q.stop);
        else if (bus_addr == A_DBN)
            bus_rdata = DATA_W'(st_q.dbn);
        else if (bus_addr == A_ALCTL)
            bus_rdata = DATA_W'(st_q.alctl);
        else if (bus_addr == A_STAT)
            bus_rdata = DATA_W'({st_q.pend, 4'b0});
    end

    assign irq = st_q.pend && st_q.alctl[0];

    logic       pend_w, alen_w, stop_w;
    logic [5:0] sec_w;
    assign pend_w = st_q.pend;
    assign alen_w = st_q.alctl[0];
    assign stop_w = st_q.stop;
    assign sec_w  = st_q.tm.sec;

endmodule

// File: rtl/cal_rtc_chk.sv
module cal_rtc_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tick_1hz,
    input logic       bus_en,
    input logic       bus_wr,
    input logic [7:0] bus_addr,
    input logic [31:0] bus_wdata,
    input logic       irq,
    input logic       pend,
    input logic       alen,
    input logic       stopped,
    input logic [5:0] sec
);

    logic tm_wr, clr_wr;
    assign tm_wr  = bus_en && bus_wr && (bus_addr[7:5] == 3'b010);
    assign clr_wr = bus_en && bus_wr && (bus_addr == 8'h30) && bus_wdata[4];

    AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (stopped && !tm_wr) |=> $stable(sec)); // R3

    AST_SEC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (sec <= 6'd59 && !tm_wr) |=> (sec <= 6'd59)); // R4

    AST_PEND_FROM_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend) |-> $past(tick_1hz)); // R9

    AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (pend && alen)); // R10

    AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && !tick_1hz) |=> !pend); // R11

    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !clr_wr) |=> pend); // R11

endmodule

bind cal_rtc cal_rtc_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_1hz  (tick_1hz),
    .bus_en    (bus_en),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq       (irq),
    .pend      (pend_w),
    .alen      (alen_w),
    .stopped   (stop_w),
    .sec       (sec_w)
);

// File: tb/cal_rtc_test.sv
module cal_rtc_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_1hz = 1'b0;
    logic        bus_en = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    cal_rtc uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_1hz  (tick_1hz),
        .bus_en    (bus_en),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #2 d = bus_rdata;
        bus_en = 1'b0;
    endtask

    task automatic tick(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick_1hz = 1'b1;
            @(negedge clk);
            tick_1hz = 1'b0;
        end
    endtask

    task automatic expect_reg(string tag, logic [7:0] a, logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        check(tag, v, exp);
    endtask

    task automatic set_time(int y, int mo, int d, int w, int h, int mi, int s);
        wr(8'h20, 32'h1);
        wr(8'h40, y);  wr(8'h44, mo); wr(8'h48, d); wr(8'h4c, w);
        wr(8'h50, h);  wr(8'h54, mi); wr(8'h58, s);
        wr(8'h20, 32'h0);
    endtask

    task automatic expect_time(string tag, int y, int mo, int d, int w, int h, int mi, int s);
        expect_reg({tag, " year"}, 8'h40, y);
        expect_reg({tag, " month"}, 8'h44, mo);
        expect_reg({tag, " mday"}, 8'h48, d);
        expect_reg({tag, " wday"}, 8'h4c, w);
        expect_reg({tag, " hour"}, 8'h50, h);
        expect_reg({tag, " min"}, 8'h54, mi);
        expect_reg({tag, " sec"}, 8'h58, s);
    endtask

    task automatic t_reset;
        expect_time("R1 reset", 0, 1, 1, 0, 0, 0, 0);
        expect_reg("R1 stop", 8'h20, 1);
        expect_reg("R1 alarm sec", 8'h78, 0);
        expect_reg("R1 alctl", 8'h7c, 0);
        expect_reg("R1 status", 8'h30, 0);
        expect_reg("R1 debounce", 8'h2c, 0);
        check("R1 irq", irq, 0);
    endtask

    task automatic t_regmap;
        for (int i = 0; i < 7; i++) wr(8'h60 + 8'(4 * i), 32'(i + 2));
        for (int i = 0; i < 7; i++) expect_reg("R2 alarm field", 8'h60 + 8'(4 * i), 32'(i + 2));
        wr(8'h54, 32'd42);
        expect_time("R2 single field", 0, 1, 1, 0, 0, 42, 0);
    endtask

    task automatic t_stop;
        wr(8'h20, 32'h1);
        wr(8'h58, 32'd10);
        tick(3);
        expect_reg("R3 stopped sec", 8'h58, 10);
        wr(8'h20, 32'h0);
        tick(2);
        expect_reg("R3 running sec", 8'h58, 12);
    endtask

    task automatic t_hms;
        set_time(21, 5, 10, 2, 23, 59, 58);
        tick(1);
        expect_reg("R4 sec step", 8'h58, 59);
        tick(1);
        expect_time("R4 hour rollover", 21, 5, 11, 3, 0, 0, 0);
    endtask

    task automatic t_month;
        set_time(21, 4, 30, 1, 23, 59, 59);
        tick(1);
        expect_time("R5 30-day month", 21, 5, 1, 2, 0, 0, 0);
        set_time(21, 5, 30, 1, 23, 59, 59);
        tick(1);
        expect_time("R5 31-day month", 21, 5, 31, 2, 0, 0, 0);
        set_time(21, 12, 31, 3, 23, 59, 59);
        tick(1);
        expect_time("R5 year carry", 22, 1, 1, 4, 0, 0, 0);
    endtask

    task automatic t_leap;
        set_time(24, 2, 28, 0, 23, 59, 59);
        tick(1);
        expect_time("R6 leap 28", 24, 2, 29, 1, 0, 0, 0);
        tick(86400);
        expect_time("R6 leap 29", 24, 3, 1, 2, 0, 0, 0);
        set_time(23, 2, 28, 0, 23, 59, 59);
        tick(1);
        expect_time("R6 common", 23, 3, 1, 1, 0, 0, 0);
        set_time(0, 2, 28, 0, 23, 59, 59);
        tick(1);
        expect_time("R6 year zero", 0, 3, 1, 1, 0, 0, 0);
    endtask

    task automatic t_year;
        set_time(99, 12, 31, 5, 23, 59, 59);
        tick(1);
        expect_time("R7 year wrap", 0, 1, 1, 6, 0, 0, 0);
    endtask

    task automatic t_dow;
        set_time(30, 6, 14, 6, 23, 59, 59);
        tick(1);
        expect_time("R8 weekday wrap", 30, 6, 15, 0, 0, 0, 0);
    endtask

    task automatic t_alarm;
        set_time(21, 3, 4, 1, 10, 20, 3);
        wr(8'h78, 32'd5);
        wr(8'h74, 32'd33);
        wr(8'h7c, 32'h81);
        tick(1);
        expect_reg("R9 before match", 8'h30, 0);
        check("R10 irq low before", irq, 0);
        tick(1);
        expect_reg("R9 match pending", 8'h30, 32'h10);
        check("R10 irq high", irq, 1);
        wr(8'h7c, 32'h0);
        check("R10 irq masked", irq, 0);
        expect_reg("R10 pending kept", 8'h30, 32'h10);
        wr(8'h30, 32'hffff_ffef);
        expect_reg("R11 zero write ignored", 8'h30, 32'h10);
        wr(8'h30, 32'h10);
        expect_reg("R11 cleared", 8'h30, 0);
        wr(8'h78, 32'd6);
        wr(8'h7c, 32'h80);
        tick(1);
        expect_reg("R9 disabled no set", 8'h30, 0);
    endtask

    task automatic t_collide;
        logic [31:0] v;
        wr(8'h78, 32'd7);
        wr(8'h7c, 32'h81);
        @(negedge clk);
        tick_1hz = 1'b1;
        bus_en = 1'b1; bus_wr = 1'b1; bus_addr = 8'h30; bus_wdata = 32'h10;
        @(negedge clk);
        tick_1hz = 1'b0; bus_en = 1'b0; bus_wr = 1'b0;
        rd(8'h30, v);
        check("R11 set beats clear", v, 32'h10);
        check("R11 irq after collide", irq, 1);
        wr(8'h30, 32'h10);
        check("R11 irq after clear", irq, 0);
    endtask

    task automatic t_debounce;
        wr(8'h2c, 32'hff);
        expect_reg("R12 debounce", 8'h2c, 32'h7);
        expect_reg("R12 time untouched", 8'h58, 7);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_regmap;
        t_stop;
        t_hms;
        t_month;
        t_leap;
        t_year;
        t_dow;
        t_alarm;
        t_collide;
        t_debounce;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule